// File: doc/BRIEF.md
# Index-Half Register Instruction Executor

This block executes the 8-bit operations that treat the upper and lower byte of the two 16-bit index registers as ordinary operands. Bytes arrive one per cycle on a valid-qualified input. An instruction is a selector byte, then an opcode byte, and for the two immediate-load opcodes a third data byte. The selector chooses which index register is used. In the opcode that follows, an operand field that would normally name H or L names the upper or lower byte of that index register.

The block holds its own register state: the accumulator, four general registers (B, C, D, E), the four index halves and an 8-bit flag byte. All of these are visible on output ports. A one-cycle completion strobe marks each executed instruction. A separate one-cycle strobe marks a rejected byte sequence, and a rejected sequence changes no state. The only way to load a value is through the instruction set: an immediate load into an index half, then a copy from that half.

Top module: `idxhalf_exec`

## Requirements
- R1: After synchronous reset every data register and the flag byte read zero, both strobes are low, and the block waits for a selector byte.
- R2: Selector 0xDD makes operand code 4 mean the IX upper byte and code 5 the IX lower byte. Selector 0xFD maps the same codes to the IY bytes. The halves of the other index register are never written.
- R3: Opcodes 0x24/0x2C increment and 0x25/0x2D decrement the upper/lower half. S, Z, H and P/V (overflow: 0x7F→0x80 on increment, 0x80→0x7F on decrement) are updated. N is 0 for increment and 1 for decrement. The carry flag keeps its value.
- R4: Opcodes 0x26/0x2E take the byte after the opcode as an immediate and write it into the upper/lower half. Flags are unchanged.
- R5: Opcodes 0x44/0x45, 0x4C/0x4D, 0x54/0x55, 0x5C/0x5D and 0x7C/0x7D copy the upper/lower half into B, C, D, E and A. Flags are unchanged.
- R6: An opcode 01_ddd_sss with register codes 0=B, 1=C, 2=D, 3=E, 4=upper half, 5=lower half, 7=A copies register sss into register ddd when at least one of the two codes is 4 or 5 and neither is 6. This includes 0x65 (lower to upper) and 0x6C (upper to lower). Flags are unchanged.
- R7: An opcode 10_ooo_10x applies ALU operation ooo to A and the upper (x=0) or lower (x=1) half: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow. H is the carry or borrow out of bit 3, C is the carry or borrow out of bit 7, P/V is signed overflow, and N is 1 only for subtraction.
- R8: ALU operations 4 (AND), 5 (XOR) and 6 (OR) write A. AND sets H=1 and XOR/OR set H=0. All three clear C and N and set P/V when the result has an even number of ones.
- R9: ALU operation 7 (compare) sets the flags exactly as a subtraction would but leaves A unchanged.
- R10: Flag byte layout: S=bit 7 (result bit 7), Z=bit 6 (result zero), H=bit 4, P/V=bit 2, N=bit 1, C=bit 0. Bits 5 and 3 always read 0.
- R11: A first byte other than 0xDD/0xFD, or any opcode not listed in R3 to R9 (including those naming code 6), raises the reject strobe for one cycle. The rejected byte is consumed, no register or flag changes, and the next byte is treated as a selector.
- R12: The completion strobe is high for exactly one cycle, in the cycle after the final byte of an instruction is accepted. The new register and flag values are visible in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid_i | input | 1 | Byte on byte_i is accepted this cycle |
| byte_i | input | 8 | Instruction stream byte |
| done_o | output | 1 | Instruction completed (one-cycle pulse) |
| illegal_o | output | 1 | Byte sequence rejected (one-cycle pulse) |
| acc_o | output | 8 | Accumulator A |
| b_o | output | 8 | Register B |
| c_o | output | 8 | Register C |
| d_o | output | 8 | Register D |
| e_o | output | 8 | Register E |
| ixh_o | output | 8 | IX upper byte |
| ixl_o | output | 8 | IX lower byte |
| iyh_o | output | 8 | IY upper byte |
| iyl_o | output | 8 | IY lower byte |
| flags_o | output | 8 | Flag byte |

## Verification
The hardest cases to reach are the flag corner cases: half-carry and signed overflow at 0x7F/0x80, borrow with a carry already set, and a carry that an increment must keep. Every operand has to be built first through immediate loads and register copies, because the block has no other way to load data. The stimulus therefore chains loads, copies into A and ALU operations to place chosen values and a chosen carry before each flag-sensitive opcode. A seeded sweep then mixes selectors, the whole opcode space and non-selector first bytes. This sweep reaches the rejection paths and the code-6 holes in the middle of otherwise legal rows.

// File: rtl/zxh_pkg.sv
package zxh_pkg;

    localparam int          DW      = 8;
    localparam logic [7:0]  SEL_IX  = 8'hDD;
    localparam logic [7:0]  SEL_IY  = 8'hFD;

    localparam logic [2:0]  RC_HI   = 3'd4;
    localparam logic [2:0]  RC_LO   = 3'd5;
    localparam logic [2:0]  RC_MEM  = 3'd6;
    localparam logic [2:0]  RC_ACC  = 3'd7;

    localparam int FB_S  = 7;
    localparam int FB_Z  = 6;
    localparam int FB_H  = 4;
    localparam int FB_PV = 2;
    localparam int FB_N  = 1;
    localparam int FB_C  = 0;

    // first eight values follow the opcode's ooo field
    typedef enum logic [3:0] {
        OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_AND, OP_XOR, OP_OR, OP_CP,
        OP_INC, OP_DEC
    } alu_op_e;

    typedef enum logic [2:0] {
        K_NONE, K_STEP, K_LDI, K_MOV, K_ALU
    } kind_e;

    typedef enum logic [1:0] {
        S_SEL, S_OPC, S_IMM
    } seq_state_e;

    typedef struct packed {
        logic    legal;
        kind_e   kind;
        alu_op_e aop;
        logic [2:0] src;
        logic [2:0] dst;
    } insn_t;

    function automatic logic is_half(input logic [2:0] code);
        return (code == RC_HI) || (code == RC_LO);
    endfunction

    function automatic logic is_plain(input logic [2:0] code);
        return (code <= 3'd3) || (code == RC_ACC);
    endfunction

    function automatic insn_t decode(input logic [7:0] op);
        insn_t d;
        d.legal = 1'b0;
        d.kind  = K_NONE;
        d.aop   = OP_ADD;
        d.src   = op[2:0];
        d.dst   = op[5:3];
        case (op)
            8'h24, 8'h2C: begin
                d.legal = 1'b1; d.kind = K_STEP; d.aop = OP_INC;
                d.dst   = op[3] ? RC_LO : RC_HI;
            end
            8'h25, 8'h2D: begin
                d.legal = 1'b1; d.kind = K_STEP; d.aop = OP_DEC;
                d.dst   = op[3] ? RC_LO : RC_HI;
            end
            8'h26, 8'h2E: begin
                d.legal = 1'b1; d.kind = K_LDI;
                d.dst   = op[3] ? RC_LO : RC_HI;
            end
            default: begin
                if (op[7:6] == 2'b01) begin
                    d.kind  = K_MOV;
                    d.legal = (is_half(op[5:3]) && (op[2:0] != RC_MEM)) ||
                              (is_half(op[2:0]) && is_plain(op[5:3]));
                end else if (op[7:6] == 2'b10) begin
                    d.kind  = K_ALU;
                    d.aop   = alu_op_e'({1'b0, op[5:3]});
                    d.dst   = RC_ACC;
                    d.legal = is_half(op[2:0]);
                end
            end
        endcase
        if (!d.legal) d.kind = K_NONE;
        return d;
    endfunction

endpackage

// File: rtl/zxh_seq.sv
module zxh_seq
    import zxh_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            byte_valid_i,
    input  logic [DW-1:0]   byte_i,
    output logic            go_o,
    output logic            bad_o,
    output insn_t           insn_o,
    output logic [DW-1:0]   imm_o,
    output logic            sel_iy_o
);

    seq_state_e    state_q;
    logic [DW-1:0] op_q;
    logic          sel_iy_q;
    insn_t         dec_now;
    logic          is_sel;

    assign dec_now = decode(byte_i);
    assign is_sel  = (byte_i == SEL_IX) || (byte_i == SEL_IY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_SEL;
            op_q     <= '0;
            sel_iy_q <= 1'b0;
        end else if (byte_valid_i) begin
            case (state_q)
                S_SEL: if (is_sel) begin
                    sel_iy_q <= (byte_i == SEL_IY);
                    state_q  <= S_OPC;
                end
                S_OPC: begin
                    op_q    <= byte_i;
                    state_q <= (dec_now.kind == K_LDI) ? S_IMM : S_SEL;
                end
                default: state_q <= S_SEL;
            endcase
        end
    end

    always_comb begin
        insn_o   = (state_q == S_IMM) ? decode(op_q) : dec_now;
        imm_o    = byte_i;
        sel_iy_o = sel_iy_q;
        go_o     = byte_valid_i &&
                   (((state_q == S_OPC) && dec_now.legal && (dec_now.kind != K_LDI)) ||
                    (state_q == S_IMM));
        bad_o    = byte_valid_i &&
                   (((state_q == S_SEL) && !is_sel) ||
                    ((state_q == S_OPC) && !dec_now.legal));
    end

    AST_IMM_AFTER_OPC: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IMM) |-> ($past(state_q) == S_OPC)); // R4

endmodule

// File: rtl/zxh_alu.sv
module zxh_alu
    import zxh_pkg::*;
(
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            carry_in,
    output logic [DW-1:0]   res,
    output logic [DW-1:0]   flags
);

    logic [DW:0]  wide;
    logic [4:0]   nib;
    logic         cin, h, v, n, c;

    always_comb begin
        cin  = ((op == OP_ADC) || (op == OP_SBC)) ? carry_in : 1'b0;
        wide = '0;
        nib  = '0;
        h    = 1'b0;
        v    = 1'b0;
        n    = 1'b0;
        c    = 1'b0;
        case (op)
            OP_ADD, OP_ADC: begin
                wide = {1'b0, a} + {1'b0, b} + 9'(cin);
                nib  = {1'b0, a[3:0]} + {1'b0, b[3:0]} + 5'(cin);
                h    = nib[4];
                c    = wide[DW];
                v    = (a[7] == b[7]) && (wide[7] != a[7]);
            end
            OP_SUB, OP_SBC, OP_CP: begin
                wide = {1'b0, a} - {1'b0, b} - 9'(cin);
                nib  = {1'b0, a[3:0]} - {1'b0, b[3:0]} - 5'(cin);
                h    = nib[4];
                c    = wide[DW];
                v    = (a[7] != b[7]) && (wide[7] != a[7]);
                n    = 1'b1;
            end
            OP_AND: begin
                wide = {1'b0, a & b};
                h    = 1'b1;
                v    = ~^wide[DW-1:0];
            end
            OP_XOR: begin
                wide = {1'b0, a ^ b};
                v    = ~^wide[DW-1:0];
            end
            OP_OR: begin
                wide = {1'b0, a | b};
                v    = ~^wide[DW-1:0];
            end
            OP_INC: begin
                wide = {1'b0, b} + 9'd1;
                h    = (b[3:0] == 4'hF);
                v    = (b == 8'h7F);
                c    = carry_in;
            end
            default: begin
                wide = {1'b0, b} - 9'd1;
                h    = (b[3:0] == 4'h0);
                v    = (b == 8'h80);
                n    = 1'b1;
                c    = carry_in;
            end
        endcase
        res          = wide[DW-1:0];
        flags        = '0;
        flags[FB_S]  = res[7];
        flags[FB_Z]  = (res == '0);
        flags[FB_H]  = h;
        flags[FB_PV] = v;
        flags[FB_N]  = n;
        flags[FB_C]  = c;
    end

endmodule

// File: rtl/zxh_regs.sv
module zxh_regs
    import zxh_pkg::*;
#(
    parameter int NGPR = 4,
    parameter int NIDX = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic            sel_iy,
    input  logic [2:0]      wcode,
    input  logic [DW-1:0]   wdata,
    input  logic            fwe,
    input  logic [DW-1:0]   fdata,
    output logic [DW-1:0]   gpr_o [NGPR],
    output logic [DW-1:0]   hi_o  [NIDX],
    output logic [DW-1:0]   lo_o  [NIDX],
    output logic [DW-1:0]   acc_o,
    output logic [DW-1:0]   f_o
);

    for (genvar g = 0; g < NGPR; g++) begin : g_gpr
        localparam logic [2:0] CODE = 3'(g);
        always_ff @(posedge clk) begin
            if (rst)                         gpr_o[g] <= '0;
            else if (we && (wcode == CODE))  gpr_o[g] <= wdata;
        end
    end

    for (genvar p = 0; p < NIDX; p++) begin : g_idx
        localparam logic PSEL = 1'(p);
        always_ff @(posedge clk) begin
            if (rst) begin
                hi_o[p] <= '0;
                lo_o[p] <= '0;
            end else if (we && (sel_iy == PSEL)) begin
                if (wcode == RC_HI) hi_o[p] <= wdata;
                if (wcode == RC_LO) lo_o[p] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o <= '0;
            f_o   <= '0;
        end else begin
            if (we && (wcode == RC_ACC)) acc_o <= wdata;
            if (fwe)                     f_o   <= fdata;
        end
    end

    AST_FLAG_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (f_o[5] == 1'b0) && (f_o[3] == 1'b0)); // R10

endmodule

// File: rtl/idxhalf_exec.sv
module idxhalf_exec
    import zxh_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            byte_valid_i,
    input  logic [7:0]      byte_i,
    output logic            done_o,
    output logic            illegal_o,
    output logic [7:0]      acc_o,
    output logic [7:0]      b_o,
    output logic [7:0]      c_o,
    output logic [7:0]      d_o,
    output logic [7:0]      e_o,
    output logic [7:0]      ixh_o,
    output logic [7:0]      ixl_o,
    output logic [7:0]      iyh_o,
    output logic [7:0]      iyl_o,
    output logic [7:0]      flags_o
);

    localparam int NGPR = 4;
    localparam int NIDX = 2;

    logic          go, bad, sel_iy, run;
    insn_t         insn;
    logic [DW-1:0] imm, operand, alu_res, alu_flags, wdata;
    logic [2:0]    rd_code, wcode;
    logic          we, fwe;
    logic [DW-1:0] gpr [NGPR];
    logic [DW-1:0] hi  [NIDX];
    logic [DW-1:0] lo  [NIDX];

    zxh_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .byte_valid_i (byte_valid_i),
        .byte_i       (byte_i),
        .go_o         (go),
        .bad_o        (bad),
        .insn_o       (insn),
        .imm_o        (imm),
        .sel_iy_o     (sel_iy)
    );

    // operand read: codes 4/5 follow the selected index register
    assign rd_code = (insn.kind == K_STEP) ? insn.dst : insn.src;

    always_comb begin
        case (rd_code)
            3'd0, 3'd1, 3'd2, 3'd3: operand = gpr[rd_code[1:0]];
            RC_HI:                  operand = hi[sel_iy];
            RC_LO:                  operand = lo[sel_iy];
            RC_ACC:                 operand = acc_o;
            default:                operand = '0;
        endcase
    end

    zxh_alu u_alu (
        .op       (insn.aop),
        .a        (acc_o),
        .b        (operand),
        .carry_in (flags_o[FB_C]),
        .res      (alu_res),
        .flags    (alu_flags)
    );

    always_comb begin
        run   = go && insn.legal;
        wcode = (insn.kind == K_ALU) ? RC_ACC : insn.dst;
        case (insn.kind)
            K_LDI:   wdata = imm;
            K_MOV:   wdata = operand;
            default: wdata = alu_res;
        endcase
        we  = run && ((insn.kind == K_STEP) || (insn.kind == K_LDI) ||
                      (insn.kind == K_MOV)  ||
                      ((insn.kind == K_ALU) && (insn.aop != OP_CP)));
        fwe = run && ((insn.kind == K_STEP) || (insn.kind == K_ALU));
    end

    zxh_regs #(.NGPR(NGPR), .NIDX(NIDX)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (we),
        .sel_iy (sel_iy),
        .wcode  (wcode),
        .wdata  (wdata),
        .fwe    (fwe),
        .fdata  (alu_flags),
        .gpr_o  (gpr),
        .hi_o   (hi),
        .lo_o   (lo),
        .acc_o  (acc_o),
        .f_o    (flags_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o    <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            done_o    <= run;
            illegal_o <= bad;
        end
    end

    assign b_o   = gpr[0];
    assign c_o   = gpr[1];
    assign d_o   = gpr[2];
    assign e_o   = gpr[3];
    assign ixh_o = hi[0];
    assign ixl_o = lo[0];
    assign iyh_o = hi[1];
    assign iyl_o = lo[1];

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done_o && illegal_o)); // R11

    AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $stable({acc_o, b_o, c_o, d_o, e_o, ixh_o, ixl_o,
                               iyh_o, iyl_o, flags_o})); // R11

    AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(run && (insn.kind == K_STEP)))
        |-> (flags_o[FB_C] == $past(flags_o[FB_C]))); // R3

    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(run && (insn.kind == K_ALU) && (insn.aop == OP_CP)))
        |-> $stable(acc_o)); // R9

    AST_AND_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(run && (insn.kind == K_ALU) && (insn.aop == OP_AND)))
        |-> (flags_o[FB_H] && !flags_o[FB_C] && !flags_o[FB_N])); // R8

    AST_MOVE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(run && ((insn.kind == K_MOV) || (insn.kind == K_LDI))))
        |-> $stable(flags_o)); // R6

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R12

endmodule

// File: tb/idxhalf_exec_tb_top.sv
module idxhalf_exec_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic byte_valid_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic done_o, illegal_o;
    logic [7:0] acc_o, b_o, c_o, d_o, e_o, ixh_o, ixl_o, iyh_o, iyl_o, flags_o;

    always #2.5 clk = ~clk;   // 200 MHz

    idxhalf_exec dut_i (
        .clk(clk), .rst(rst), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
        .done_o(done_o), .illegal_o(illegal_o), .acc_o(acc_o), .b_o(b_o),
        .c_o(c_o), .d_o(d_o), .e_o(e_o), .ixh_o(ixh_o), .ixl_o(ixl_o),
        .iyh_o(iyh_o), .iyl_o(iyl_o), .flags_o(flags_o)
    );

    typedef struct {
        string       tag;
        bit          ill;
        logic [79:0] snap;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;
    int cyc = 0;

    // model: 0 B,1 C,2 D,3 E,4 IXH,5 IXL,6 IYH,7 IYL,8 A,9 F
    logic [7:0] mr [10];
    logic [31:0] lcg = 32'h1234_5678;

    function automatic logic [79:0] model_snap();
        return {mr[9], mr[8], mr[7], mr[6], mr[5], mr[4], mr[3], mr[2], mr[1], mr[0]};
    endfunction

    function automatic logic [79:0] dut_snap();
        return {flags_o, acc_o, iyl_o, iyh_o, ixl_o, ixh_o, e_o, d_o, c_o, b_o};
    endfunction

    function automatic int sx(input int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    function automatic logic [7:0] mkf(input int r, input bit h, input bit v,
                                       input bit n, input bit c);
        logic [7:0] rb = 8'(r);
        return {rb[7], (rb == 8'h00), 1'b0, h, 1'b0, v, n, c};
    endfunction

    function automatic int slot(input logic [2:0] code, input bit iy);
        case (code)
            3'd0, 3'd1, 3'd2, 3'd3: return int'(code);
            3'd4: return iy ? 6 : 4;
            3'd5: return iy ? 7 : 5;
            3'd7: return 8;
            default: return -1;
        endcase
    endfunction

    task automatic put(input logic [7:0] b);
        byte_i = b;
        byte_valid_i = 1'b1;
        @(negedge clk);
        byte_valid_i = 1'b0;
    endtask

    task automatic push(input string tag, input bit ill);
        exp_t e;
        e.tag  = tag;
        e.ill  = ill;
        e.snap = model_snap();
        q.push_back(e);
    endtask

    // driver: updates the model, pushes the expected item, drives the bytes
    task automatic run(input logic [7:0] pfx, input logic [7:0] op,
                       input logic [7:0] imm, input string tag);
        bit iy, legal, ldi;
        int s, d, a, b, r, k, cin, t;
        bit h, v, n, c;
        if (pfx != 8'hDD && pfx != 8'hFD) begin
            push(tag, 1'b1);
            put(pfx);
            return;
        end
        iy = (pfx == 8'hFD);
        legal = 1'b0;
        ldi = 1'b0;
        if (op == 8'h24 || op == 8'h2C || op == 8'h25 || op == 8'h2D) begin
            legal = 1'b1;
            d = slot(op[3] ? 3'd5 : 3'd4, iy);
            b = int'(mr[d]);
            c = mr[9][0];
            if (op[0]) begin
                r = (b + 255) % 256; h = (b % 16) == 0; v = (b == 128); n = 1'b1;
            end else begin
                r = (b + 1) % 256; h = (b % 16) == 15; v = (b == 127); n = 1'b0;
            end
            mr[d] = 8'(r);
            mr[9] = mkf(r, h, v, n, c);
        end else if (op == 8'h26 || op == 8'h2E) begin
            legal = 1'b1;
            ldi = 1'b1;
            mr[slot(op[3] ? 3'd5 : 3'd4, iy)] = imm;
        end else if (op[7:6] == 2'b01) begin
            d = slot(op[5:3], iy);
            s = slot(op[2:0], iy);
            legal = (d >= 0) && (s >= 0) &&
                    (op[5:3] == 3'd4 || op[5:3] == 3'd5 ||
                     op[2:0] == 3'd4 || op[2:0] == 3'd5);
            if (legal) mr[d] = mr[s];
        end else if (op[7:6] == 2'b10 && (op[2:0] == 3'd4 || op[2:0] == 3'd5)) begin
            legal = 1'b1;
            k = int'(op[5:3]);
            a = int'(mr[8]);
            b = int'(mr[slot(op[2:0], iy)]);
            cin = (k == 1 || k == 3) ? int'(mr[9][0]) : 0;
            n = 1'b0;
            if (k <= 1) begin
                t = a + b + cin;
                h = ((a % 16) + (b % 16) + cin) > 15;
                c = t > 255;
                s = sx(a) + sx(b) + cin;
                v = (s > 127) || (s < -128);
                r = t % 256;
            end else if (k == 2 || k == 3 || k == 7) begin
                t = a - b - cin;
                h = ((a % 16) - (b % 16) - cin) < 0;
                c = t < 0;
                s = sx(a) - sx(b) - cin;
                v = (s > 127) || (s < -128);
                r = (t + 256) % 256;
                n = 1'b1;
            end else begin
                r = (k == 4) ? (a & b) : (k == 5) ? (a ^ b) : (a | b);
                h = (k == 4);
                c = 1'b0;
                v = ($countones(8'(r)) % 2) == 0;
            end
            if (k != 7) mr[8] = 8'(r);
            mr[9] = mkf(r, h, v, n, c);
        end
        push(tag, !legal);
        put(pfx);
        put(op);
        if (ldi) put(imm);
    endtask

    // monitor: pops and compares on each strobe
    always @(negedge clk) begin
        if (!rst && !finished && (done_o || illegal_o)) begin
            total++;
            if (q.size() == 0) begin
                bad++;
                $display("FAIL R12 unexpected strobe done=%0b illegal=%0b exp none",
                         done_o, illegal_o);
            end else begin
                exp_t e;
                e = q.pop_front();
                if ((illegal_o != e.ill) || (done_o == e.ill) || (dut_snap() != e.snap)) begin
                    bad++;
                    $display("FAIL %s ill=%0b done=%0b state=%h exp ill=%0b state=%h",
                             e.tag, illegal_o, done_o, dut_snap(), e.ill, e.snap);
                end
            end
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000 && !finished) begin
                bad++;
                total++;
                $display("FAIL watchdog expired at cycle %0d exp completion", cyc);
                finish_run();
            end
        end
    end

    function automatic logic [31:0] nxt();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg >> 8;
    endfunction

    initial begin
        logic [31:0] rv;
        logic [7:0] pfx, op;
        for (int i = 0; i < 10; i++) mr[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        total++;
        if (dut_snap() !== 80'h0 || done_o !== 1'b0 || illegal_o !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset state=%h done=%0b ill=%0b exp 0", dut_snap(), done_o, illegal_o);
        end
        // R4 / R2 immediate loads into each half
        run(8'hDD, 8'h26, 8'h12, "R4");
        run(8'hFD, 8'h2E, 8'h34, "R4");
        run(8'hDD, 8'h2E, 8'hF0, "R2");
        run(8'hFD, 8'h26, 8'h80, "R2");
        // R5 copies out of the halves
        run(8'hDD, 8'h44, 8'h00, "R5");
        run(8'hFD, 8'h4D, 8'h00, "R5");
        run(8'hDD, 8'h54, 8'h00, "R5");
        run(8'hFD, 8'h5C, 8'h00, "R5");
        run(8'hDD, 8'h7D, 8'h00, "R5");
        // R6 writes into the halves
        run(8'hDD, 8'h65, 8'h00, "R6");
        run(8'hFD, 8'h6C, 8'h00, "R6");
        run(8'hDD, 8'h61, 8'h00, "R6");
        run(8'hFD, 8'h6F, 8'h00, "R6");
        run(8'hDD, 8'h64, 8'h00, "R6");
        // R3 increment/decrement corners, carry kept
        run(8'hDD, 8'h2E, 8'hFF, "R4");
        run(8'hDD, 8'h2C, 8'h00, "R3");
        run(8'hFD, 8'h25, 8'h00, "R3");
        run(8'hFD, 8'h24, 8'h00, "R3");
        run(8'hDD, 8'h26, 8'h7F, "R4");
        run(8'hDD, 8'h24, 8'h00, "R3");
        // R7 carry out then step that must keep it
        run(8'hDD, 8'h2E, 8'hF0, "R4");
        run(8'hDD, 8'h7D, 8'h00, "R5");
        run(8'hDD, 8'h85, 8'h00, "R7");
        run(8'hDD, 8'h2D, 8'h00, "R3");
        run(8'hDD, 8'h8C, 8'h00, "R7");
        run(8'hFD, 8'h9D, 8'h00, "R7");
        run(8'hFD, 8'h94, 8'h00, "R7");
        // R8 logic ops, R9 compare
        run(8'hDD, 8'hA4, 8'h00, "R8");
        run(8'hFD, 8'hAD, 8'h00, "R8");
        run(8'hDD, 8'hB5, 8'h00, "R8");
        run(8'hFD, 8'hBC, 8'h00, "R9");
        run(8'hDD, 8'hBD, 8'h00, "R9");
        // R11 rejections
        run(8'h3E, 8'h00, 8'h00, "R11");
        run(8'hDD, 8'h66, 8'h00, "R11");
        run(8'hFD, 8'h6E, 8'h00, "R11");
        run(8'hDD, 8'h74, 8'h00, "R11");
        run(8'hDD, 8'h40, 8'h00, "R11");
        run(8'hFD, 8'h86, 8'h00, "R11");
        run(8'hDD, 8'hDD, 8'h00, "R11");
        run(8'hFD, 8'h00, 8'h00, "R11");
        // R10 and all of the above, seeded sweep
        for (int i = 0; i < 600; i++) begin
            rv = nxt();
            if (rv[2:0] == 3'd0) pfx = rv[15:8];
            else pfx = rv[3] ? 8'hFD : 8'hDD;
            case (rv[5:4])
                2'd0: op = rv[23:16];
                2'd1: op = {2'b10, rv[18:16], 2'b10, rv[19]};
                2'd2: op = {2'b01, rv[21:16]};
                default: op = 8'h24 | {4'b0, rv[16], 3'b0} | 8'(rv[23:16] % 3);
            endcase
            run(pfx, op, rv[31:24], "R10");
        end
        repeat (4) @(negedge clk);
        // R12 every expected completion arrived
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R12 pending=%0d exp 0", q.size());
        end
        finish_run();
    end

endmodule